// File: doc/BRIEF.md
# Double-Buffered Tick-Driven PWM Channel

This block generates a pulse-width modulated pin from two down-counters that advance only on a loop-resolution tick. A duty counter sets the pin level. Its action depends on its value: at zero it leaves the pin alone, above one it asserts the pin, and at one it releases the pin. A period counter counts down to zero and then reloads both counters from software-written buffers. Software writes the buffers, a small control word and a flag-clear register through a single write port. A write changes nothing in the pulse that is under way.

Two reload styles are offered. In overwrite mode the buffered duty value replaces the active count, and the buffered enable and polarity bits are loaded at the same period boundary. This mode keeps a known weakness on purpose. When a full-on period is followed by a zero-duty period, the reload writes zero over a residual count of one before that one is processed, so the pin stays active. In add mode the reload adds the new duty value to the residual count, which lets the residual one run out and release the pin. Add mode leaves the enable and polarity bits untouched.

Top module: `lrpwm`

## Requirements
- R1: After reset, pwm_out is 0, both flags are 0, the enable bit is 0, the polarity bit is 1 (active-high), and the counters are zero, so the first tick performs a reload.
- R2: On a tick where the duty count is 0, the duty counter does not change the asserted state of the pin.
- R3: On a tick where the duty count D is greater than 1, the count becomes D-1 and the pin is asserted. With a loaded duty value 2 ≤ D ≤ P+1, the pin is asserted for D-1 of the period's ticks.
- R4: On a tick where the duty count is 1, the count becomes 0, the pin is released, and the end-of-duty flag (eod_irq) is set.
- R5: The period counter decrements on each tick. On a tick where it is 0, it reloads from the period buffer P and sets eop_irq, so a period lasts P+1 ticks. The duty counter takes its reload value on the same tick.
- R6: A duty value of P+2 keeps the pin asserted for the whole period and leaves a residual duty count of 1 at the reload tick.
- R7: In overwrite mode (control bit 2 = 0), the reload writes the duty buffer over the residual count. A switch from duty P+2 to duty 0 therefore leaves the pin asserted for the following periods.
- R8: In add mode (control bit 2 = 1), with a nonzero duty buffer B, the reload writes residual+B-1 if the residual is nonzero and B if it is zero. With B = 0, the residual is kept as it is.
- R9: In add mode, a switch from duty P+2 to duty 0 releases the pin on the first tick of the zero-duty period and sets eod_irq in that period.
- R10: At the reload tick, overwrite mode loads the enable (control bit 0) and polarity (control bit 1, 1 = active-high) bits. Add mode leaves both bits unchanged.
- R11: Writes to the duty buffer (address 1), the period buffer (address 2) and the control word (address 0) do not change the period in progress. The control mode bit is the only exception: it takes effect at once.
- R12: Both flags stay set until a write to address 3 clears them, with bit 0 clearing eod_irq and bit 1 clearing eop_irq. A set in the same cycle takes priority over the clear.
- R13: While the loaded enable bit is 0, pwm_out sits at the inactive level (the inverse of polarity). The counters keep running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_tick | input | 1 | Loop-resolution tick; counters advance only when it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 duty buffer, 2 period buffer, 3 flag clear |
| wr_data | input | CW | Write data |
| pwm_out | output | 1 | Registered PWM pin |
| eod_irq | output | 1 | Sticky end-of-duty flag |
| eop_irq | output | 1 | Sticky end-of-period flag |

## Verification
The assertions assume that software programs a duty value of at most P+2. Under that limit the residual at a reload is always 0 or 1, and the add rule cannot build up an error from one period to the next. The assertions need nothing from the tick pattern or from the timing of writes. The stimulus, random and directed alike, draws each duty value from 0 to P+2 for the period value written with it. It places every write inside a period, before that period's reload tick, so each set of values applies to exactly the next period.

// File: rtl/lrpwm_pkg.sv
package lrpwm_pkg;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned CLR_EOD = 0;
  localparam int unsigned CLR_EOP = 1;
  localparam logic        RST_POL = 1'b1;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTL  = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_PER  = 2'd2,
    SEL_CLR  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic mode;  // 1: add reload, 0: overwrite reload
    logic pol;   // active level
    logic en;    // channel enable
  } ctl_t;
endpackage

// File: rtl/lrpwm_regs.sv
module lrpwm_regs
  import lrpwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              eod_set,
  input  logic              eop_set,
  output ctl_t              ctl_buf,
  output logic [CW-1:0]     duty_buf,
  output logic [CW-1:0]     per_buf,
  output logic              eod_irq,
  output logic              eop_irq
);
  logic clr_eod, clr_eop;

  assign clr_eod = wr_en && (reg_sel_e'(wr_addr) == SEL_CLR) && wr_data[CLR_EOD];
  assign clr_eop = wr_en && (reg_sel_e'(wr_addr) == SEL_CLR) && wr_data[CLR_EOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_buf  <= '{mode: 1'b0, pol: RST_POL, en: 1'b0};
      duty_buf <= '0;
      per_buf  <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_CTL:  ctl_buf  <= ctl_t'(wr_data[$bits(ctl_t)-1:0]);
        SEL_DUTY: duty_buf <= wr_data;
        SEL_PER:  per_buf  <= wr_data;
        default:  ;
      endcase
    end
  end

  // set takes priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      eod_irq <= 1'b0;
      eop_irq <= 1'b0;
    end else begin
      eod_irq <= eod_set | (eod_irq & ~clr_eod);
      eop_irq <= eop_set | (eop_irq & ~clr_eop);
    end
  end
endmodule

// File: rtl/lrpwm_period.sv
module lrpwm_period #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] per_buf,
  output logic [CW-1:0] per_cnt,
  output logic          reload
);
  assign reload = tick && (per_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)         per_cnt <= '0;
    else if (reload) per_cnt <= per_buf;
    else if (tick)   per_cnt <= per_cnt - CW'(1);
  end
endmodule

// File: rtl/lrpwm_duty.sv
module lrpwm_duty #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          reload,
  input  logic          add_mode,
  input  logic [CW-1:0] duty_buf,
  output logic [CW-1:0] duty_cnt,
  output logic          asrt,
  output logic          asrt_d,
  output logic          eod_set
);
  logic [CW-1:0] stepped, load_val, duty_d;

  // three-way action chosen by the current count
  always_comb begin
    stepped = duty_cnt;
    asrt_d  = asrt;
    eod_set = 1'b0;
    if (tick) begin
      if (duty_cnt > CW'(1)) begin
        stepped = duty_cnt - CW'(1);
        asrt_d  = 1'b1;
      end else if (duty_cnt == CW'(1)) begin
        stepped = '0;
        asrt_d  = 1'b0;
        eod_set = 1'b1;
      end
    end
  end

  // reload value: plain overwrite, or add onto the residual left by this tick
  always_comb begin
    if (!add_mode)              load_val = duty_buf;
    else if (duty_buf == '0)    load_val = stepped;
    else if (stepped != '0)     load_val = stepped + duty_buf - CW'(1);
    else                        load_val = duty_buf;
    duty_d = reload ? load_val : stepped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_cnt <= '0;
      asrt     <= 1'b0;
    end else begin
      duty_cnt <= duty_d;
      asrt     <= asrt_d;
    end
  end
endmodule

// File: rtl/lrpwm.sv
module lrpwm
  import lrpwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic              pwm_out,
  output logic              eod_irq,
  output logic              eop_irq
);
  ctl_t          ctl_buf;
  logic [CW-1:0] duty_buf, per_buf, duty_cnt, per_cnt;
  logic          reload, asrt, asrt_d, eod_set;
  logic          act_en, act_pol, en_d, pol_d;

  lrpwm_regs #(.CW(CW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eod_set(eod_set), .eop_set(reload), .ctl_buf(ctl_buf), .duty_buf(duty_buf),
    .per_buf(per_buf), .eod_irq(eod_irq), .eop_irq(eop_irq)
  );

  lrpwm_period #(.CW(CW)) per_i (
    .clk(clk), .rst(rst), .tick(lr_tick), .per_buf(per_buf),
    .per_cnt(per_cnt), .reload(reload)
  );

  lrpwm_duty #(.CW(CW)) duty_i (
    .clk(clk), .rst(rst), .tick(lr_tick), .reload(reload), .add_mode(ctl_buf.mode),
    .duty_buf(duty_buf), .duty_cnt(duty_cnt), .asrt(asrt), .asrt_d(asrt_d),
    .eod_set(eod_set)
  );

  // control fields follow the buffer only on an overwrite-style reload
  always_comb begin
    en_d  = act_en;
    pol_d = act_pol;
    if (reload && !ctl_buf.mode) begin
      en_d  = ctl_buf.en;
      pol_d = ctl_buf.pol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_en  <= 1'b0;
      act_pol <= RST_POL;
      pwm_out <= ~RST_POL;
    end else begin
      act_en  <= en_d;
      act_pol <= pol_d;
      pwm_out <= (en_d && asrt_d) ? pol_d : ~pol_d;
    end
  end
endmodule

// File: rtl/lrpwm_chk.sv
module lrpwm_chk
  import lrpwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lr_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        clr_bits,
  input logic [CW-1:0]     duty_cnt,
  input logic [CW-1:0]     per_cnt,
  input logic              asrt,
  input logic              act_en,
  input logic              act_pol,
  input logic              pwm_out,
  input logic              eod_irq,
  input logic              eop_irq,
  input logic [CW-1:0]     duty_buf,
  input logic [CW-1:0]     per_buf,
  input ctl_t              ctl_buf
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == ADDR_W'(SEL_CLR));

  // R2
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lr_tick && duty_cnt == '0) |=> $stable(asrt));

  // R3
  duty_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lr_tick && duty_cnt > CW'(1) && per_cnt != '0) |=> (asrt && duty_cnt == $past(duty_cnt) - CW'(1)));

  // R4
  duty_end_chk: assert property (@(posedge clk) disable iff (rst)
    (lr_tick && duty_cnt == CW'(1)) |=> (!asrt && eod_irq));

  // R5
  per_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (lr_tick && per_cnt == '0) |=> (per_cnt == $past(per_buf) && eop_irq));

  // R5
  per_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lr_tick && per_cnt != '0) |=> (per_cnt == $past(per_cnt) - CW'(1)));

  // R7
  overwrite_load_chk: assert property (@(posedge clk) disable iff (rst)
    (lr_tick && per_cnt == '0 && !ctl_buf.mode) |=>
      (duty_cnt == $past(duty_buf) && act_en == $past(ctl_buf.en) && act_pol == $past(ctl_buf.pol)));

  // R10
  add_keeps_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_buf.mode) |=> ($stable(act_en) && $stable(act_pol)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!lr_tick) |=> ($stable(duty_cnt) && $stable(per_cnt) && $stable(asrt)));

  // R12
  eod_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (eod_irq && !(clr_wr && clr_bits[CLR_EOD])) |=> eod_irq);

  // R12
  eop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (eop_irq && !(clr_wr && clr_bits[CLR_EOP])) |=> eop_irq);

  // R13
  off_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_en) |-> (pwm_out == ~act_pol));
endmodule

bind lrpwm lrpwm_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst(rst), .lr_tick(lr_tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .clr_bits(wr_data[1:0]), .duty_cnt(duty_cnt), .per_cnt(per_cnt), .asrt(asrt),
  .act_en(act_en), .act_pol(act_pol), .pwm_out(pwm_out), .eod_irq(eod_irq),
  .eop_irq(eop_irq), .duty_buf(duty_buf), .per_buf(per_buf), .ctl_buf(ctl_buf)
);

// File: tb/lrpwm_tb_top.sv
module lrpwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 1'b0, rst = 1'b1, lr_tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic pwm_out, eod_irq, eop_irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // buffer shadow and per-period model
  int b_duty = 0, b_per = 0;
  bit b_en = 0, b_pol = 1, b_mode = 0;
  int m_L = 0, m_P = 0, cnt = 0;
  bit m_lvl = 0, m_en = 0, m_pol = 1;
  string m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lrpwm #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .lr_tick(lr_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .eod_irq(eod_irq), .eop_irq(eop_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // asserted samples on ticks before the reload tick of a period
  function automatic int mid_asrt(int L, int P, bit lvl);
    if (L == 0) return lvl ? P : 0;
    return (L - 1 < P) ? L - 1 : P;
  endfunction

  function automatic bit end_lvl(int L, int P, bit lvl);
    return (L >= P + 2) || (L == 0 && lvl);
  endfunction

  function automatic int residual(int L, int P);
    return (L >= P + 2) ? L - P - 1 : 0;
  endfunction

  // R8 add-style reload rule
  function automatic int add_load(int res, int d);
    if (d == 0) return res;
    return (res != 0) ? res + d - 1 : d;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[CW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_buf(input int d, input int p, input bit en, input bit pol, input bit mode);
    wr(1, d);
    wr(2, p);
    wr(0, {29'd0, mode, pol, en});
    b_duty = d; b_per = p; b_en = en; b_pol = pol; b_mode = mode;
  endtask

  task automatic do_tick();
    @(negedge clk);
    lr_tick = 1'b1;
    @(negedge clk);
    lr_tick = 1'b0;
  endtask

  task automatic close_period(input bit s, input bit midw, input int idx);
    int act, exp, res, newL;
    bit ne, np, nl, exp_eod;
    ne = b_mode ? m_en : b_en;
    np = b_mode ? m_pol : b_pol;
    nl = end_lvl(m_L, m_P, m_lvl);
    act = cnt + ((s == np) ? 1 : 0);
    exp = (m_en ? mid_asrt(m_L, m_P, m_lvl) : 0) + ((nl && ne) ? 1 : 0);
    chk(act == exp, midw ? {m_tag, " active ticks, mid-period write R11"} : {m_tag, " active ticks"}, act, exp);
    exp_eod = (m_L >= 1) && (m_L <= m_P + 1);
    chk(eod_irq == exp_eod, "R4 end-of-duty flag", int'(eod_irq), int'(exp_eod));
    chk(idx == m_P, "R5 period length", idx + 1, m_P + 1);
    res  = residual(m_L, m_P);
    newL = b_mode ? add_load(res, b_duty) : b_duty;
    if (!ne)                                    m_tag = "R13";
    else if (b_mode && (b_en != m_en || b_pol != m_pol)) m_tag = "R10";
    else if (b_mode && res == 1 && b_duty == 0) m_tag = "R9";
    else if (b_mode)                            m_tag = "R8";
    else if (b_duty == 0 && nl)                 m_tag = "R7";
    else if (b_duty == 0)                       m_tag = "R2";
    else if (b_duty == 1)                       m_tag = "R4";
    else if (b_duty >= b_per + 2)               m_tag = "R6";
    else                                        m_tag = "R3";
    m_L = newL; m_P = b_per; m_lvl = nl; m_en = ne; m_pol = np;
    wr(3, 3);
    chk(!eod_irq && !eop_irq, "R12 write-one-to-clear", int'({eod_irq, eop_irq}), 0);
  endtask

  // writes values during the current period, then runs it to its end
  task automatic run_period(input int d, input int p, input bit en, input bit pol, input bit mode);
    int idx, wr_at;
    bit done, wrote, midw;
    idx = 0; done = 0; wrote = 0; midw = 0; cnt = 0; wr_at = -1;
    if (m_P == 0) begin
      write_buf(d, p, en, pol, mode);
      wrote = 1;
    end else begin
      wr_at = $urandom_range(m_P - 1, 0);
    end
    while (!done) begin
      do_tick();
      if (eop_irq) begin
        close_period(pwm_out, midw, idx);
        done = 1;
      end else begin
        if (pwm_out == m_pol) cnt++;
        if (!wrote && idx == wr_at) begin
          write_buf(d, p, en, pol, mode);
          wrote = 1;
          midw = 1;
        end
        idx++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pwm_out == 1'b0, "R1 reset pin", int'(pwm_out), 0);
    chk(!eod_irq && !eop_irq, "R1 reset flags", int'({eod_irq, eop_irq}), 0);

    // overwrite mode: plain duties, 0 -> 100 -> 0 (legacy stuck case R7)
    run_period(3, 5, 1, 1, 0);
    run_period(5, 5, 1, 1, 0);
    run_period(6, 5, 1, 1, 0);
    run_period(1, 4, 1, 1, 0);
    run_period(0, 4, 1, 1, 0);
    run_period(6, 4, 1, 1, 0);
    run_period(6, 4, 1, 1, 0);
    run_period(0, 4, 1, 1, 0);
    run_period(0, 4, 1, 1, 0);
    run_period(3, 4, 1, 1, 0);
    run_period(0, 2, 1, 1, 0);
    run_period(4, 2, 1, 1, 0);
    run_period(0, 2, 1, 1, 0);
    run_period(2, 2, 1, 1, 0);

    // add mode: 0 -> 100 -> 0 releases the pin (R9)
    run_period(3, 4, 1, 1, 1);
    run_period(0, 4, 1, 1, 1);
    run_period(6, 4, 1, 1, 1);
    run_period(6, 4, 1, 1, 1);
    run_period(0, 4, 1, 1, 1);
    run_period(0, 4, 1, 1, 1);
    run_period(3, 4, 1, 1, 1);

    // control fields: add keeps them, overwrite loads them (R10)
    run_period(3, 4, 1, 0, 1);
    run_period(3, 4, 1, 0, 0);
    run_period(4, 4, 1, 0, 0);
    run_period(3, 4, 1, 1, 0);

    // disabled channel (R13), then single-tick periods
    run_period(3, 3, 0, 1, 0);
    run_period(3, 3, 0, 1, 0);
    run_period(3, 3, 1, 1, 0);
    run_period(2, 0, 1, 1, 0);
    run_period(1, 0, 1, 1, 0);
    run_period(0, 0, 1, 1, 0);
    run_period(3, 3, 1, 1, 0);

    // constrained random: duty never above period+2
    for (int i = 0; i < 60; i++) begin
      int p, d;
      bit en, pol, mode;
      p    = $urandom_range(6, 0);
      d    = $urandom_range(p + 2, 0);
      mode = $urandom_range(1, 0);
      en   = ($urandom_range(7, 0) != 0);
      pol  = $urandom_range(1, 0);
      run_period(d, p, en, pol, mode);
    end
    run_period(3, 3, 1, 1, 0);
    run_period(3, 3, 1, 1, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule